// File: doc/BRIEF.md
# Exclusive Doubleword Acquire-Load Unit

This unit executes one instruction for a 32-bit processor: an exclusive load-acquire of a doubleword. It accepts the instruction word in either of two encodings, a fixed 32-bit form and a form made of two halfwords. It reads the base register through the register-file port and issues a single 8-byte read over a valid/ready handshake. The returned 64 bits go back to two destination registers, and the endianness flag sets which half goes to which register.

When it accepts a valid instruction whose condition passes, the unit tags the base address in its local exclusive monitor. If the shared-memory attribute is set, it also raises a one-cycle mark request for the global monitor. The acquire output stays high while the read is outstanding, so the core can hold back later memory accesses until the load completes. An illegal register combination, or a word that matches neither encoding, takes the undefined-instruction exit. That exit has no side effects.

Top module: `xld_unit`

## Requirements
- R1: Fixed form (halfwordMode=0): the word matches when bits 27:20 = 8'h1B, bits 11:0 = 12'hE9F and bits 31:28 != 4'hF. Rn is bits 19:16 and the first destination is bits 15:12. The second destination is the first plus one.
- R2: Halfword form (halfwordMode=1): the first halfword sits in instrWord[31:16] and the second in instrWord[15:0]. The word matches when instrWord[31:20] = 12'hE8D and instrWord[7:0] = 8'hFF. Rn is [19:16], the first destination is [15:12] and the second destination is [11:8].
- R3: In the fixed form, an odd first destination, a first destination of 14 or an Rn of 15 makes the instruction undefined. So does a word that matches no encoding. An undefined instruction gives undefInstr=1 and done=1 together, one cycle after acceptance. It issues no request, makes no writeback and leaves the monitor unchanged.
- R4: In the halfword form, the instruction is undefined when either destination is 15, when Rn is 15 or when the two destinations are equal. It then behaves as in R3.
- R5: When a valid instruction is accepted with condPass=0, done pulses one cycle later with undefInstr=0. There is no request, no writeback, no global mark and no change to the monitor.
- R6: The request appears one cycle after acceptance, with memAddr equal to the base register value. memReqValid and memAddr stay unchanged until memReqReady is seen.
- R7: A successful acceptance sets lmonValid and stores the base address in lmonAddr, overwriting any earlier tag. lmonClear=1 clears lmonValid on the next edge, unless an acceptance happens on that same edge, in which case the acceptance wins.
- R8: gmonMarkValid pulses for exactly one cycle, alongside the first request cycle, and only when sharedAttr was 1 at acceptance. gmonMarkAddr then equals the base address.
- R9: With bigEndian=0, the first destination receives rsp[31:0] and the second receives rsp[63:32]. With bigEndian=1 the two halves are swapped.
- R10: wbEn writes both destinations in the cycle after memRspValid is seen. done pulses in the following cycle.
- R11: acquireHold is 1 from the first request cycle until the response is taken, and 0 otherwise.
- R12: baseIdx presents the Rn field of the current instrWord combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| issueValid | input | 1 | Instruction present; accepted when busy=0 |
| instrWord | input | 32 | Instruction word |
| halfwordMode | input | 1 | 1 selects the two-halfword encoding |
| condPass | input | 1 | Condition check result |
| bigEndian | input | 1 | Big-endian data order |
| sharedAttr | input | 1 | Location has the shared attribute |
| baseIdx | output | 4 | Register-file read index (Rn) |
| baseVal | input | 32 | Register-file read data |
| memReqValid | output | 1 | 8-byte read request valid |
| memReqReady | input | 1 | Request accepted |
| memAddr | output | 32 | Request address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data |
| acquireHold | output | 1 | Load outstanding; hold younger accesses |
| gmonMarkValid | output | 1 | Global monitor mark request |
| gmonMarkAddr | output | 32 | Address to mark |
| lmonClear | input | 1 | Clear the local monitor |
| lmonValid | output | 1 | Local monitor holds an exclusive tag |
| lmonAddr | output | 32 | Tagged address |
| wbEn | output | 1 | Write both destinations |
| wbIdxA | output | 4 | First destination index |
| wbDataA | output | 32 | First destination data |
| wbIdxB | output | 4 | Second destination index |
| wbDataB | output | 32 | Second destination data |
| undefInstr | output | 1 | Undefined-instruction exit |
| done | output | 1 | Instruction complete |
| busy | output | 1 | Unit occupied |

## Verification
The bench targets the register-pair rules that differ between the two forms. A design that mixed them up would derive the second destination from the wrong field, or would let an odd, equal or R15 pair reach memory instead of raising undefInstr. Undefined and condition-failed instructions are issued while the monitor already holds a tag. A leaky design would overwrite that tag, emit a global mark or write a register. Loads run with both endian orders, with the shared attribute on and off, and with zero and several cycles of ready stall. Those runs expose swapped halves, spurious marks, an address that moves during a stall, and acquire or done pulses that arrive a cycle early or late.

// File: rtl/xld_pkg.sv
package xld_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 4;
  localparam logic [IDX_W-1:0] PC_IDX = 4'd15;
  localparam logic [IDX_W-1:0] LR_IDX = 4'd14;

  typedef struct packed {
    logic             match;
    logic             unpred;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rt;
    logic [IDX_W-1:0] rt2;
  } xldDecode_t;

  typedef struct packed {
    logic capture;
    logic latchRsp;
  } ctlStrobe_t;

  function automatic xldDecode_t decodeWord(input logic [31:0] w, input logic hwMode);
    xldDecode_t d;
    d.rn = w[19:16];
    d.rt = w[15:12];
    if (!hwMode) begin
      d.rt2    = w[15:12] + 4'd1;
      d.match  = (w[27:20] == 8'h1B) && (w[11:0] == 12'hE9F) && (w[31:28] != 4'hF);
      d.unpred = w[12] || (w[15:12] == LR_IDX) || (w[19:16] == PC_IDX);
    end else begin
      d.rt2    = w[11:8];
      d.match  = (w[31:20] == 12'hE8D) && (w[7:0] == 8'hFF);
      d.unpred = (w[15:12] == PC_IDX) || (w[11:8] == PC_IDX) ||
                 (w[19:16] == PC_IDX) || (w[15:12] == w[11:8]);
    end
    return d;
  endfunction
endpackage

// File: rtl/xld_control.sv
module xld_control
  import xld_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic       condPass,
  input  xldDecode_t dec,
  input  logic       memReqReady,
  input  logic       memRspValid,
  output ctlStrobe_t strobe,
  output logic       memReqValid,
  output logic       acquireHold,
  output logic       wbEn,
  output logic       done,
  output logic       undefInstr,
  output logic       busy
);
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_WB, S_FIN} state_t;
  state_t state;
  logic   undefReg;
  logic   accept;
  logic   badDecode;

  assign accept          = issueValid && (state == S_IDLE);
  assign badDecode       = !dec.match || dec.unpred;
  assign strobe.capture  = accept && !badDecode && condPass;
  assign strobe.latchRsp = (state == S_WAIT) && memRspValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      undefReg <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          undefReg <= badDecode;
          state    <= strobe.capture ? S_REQ : S_FIN;
        end
        S_REQ:  if (memReqReady) state <= S_WAIT;
        S_WAIT: if (memRspValid) state <= S_WB;
        S_WB:   state <= S_FIN;
        default: begin
          state    <= S_IDLE;
          undefReg <= 1'b0;
        end
      endcase
    end
  end

  assign memReqValid = (state == S_REQ);
  assign acquireHold = (state == S_REQ) || (state == S_WAIT);
  assign wbEn        = (state == S_WB);
  assign done        = (state == S_FIN);
  assign undefInstr  = (state == S_FIN) && undefReg;
  assign busy        = (state != S_IDLE);

  p_req_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);
  p_wb_then_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |=> done && !wbEn);
  p_acq_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(acquireHold) |-> wbEn);
endmodule

// File: rtl/xld_datapath.sv
module xld_datapath
  import xld_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  xldDecode_t          dec,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic                bigEndian,
  input  logic                sharedAttr,
  input  logic [2*WORD_W-1:0] memRspData,
  input  logic                lmonClear,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                gmonMarkValid,
  output logic [ADDR_W-1:0]   gmonMarkAddr,
  output logic                lmonValid,
  output logic [ADDR_W-1:0]   lmonAddr,
  output logic [IDX_W-1:0]    wbIdxA,
  output logic [WORD_W-1:0]   wbDataA,
  output logic [IDX_W-1:0]    wbIdxB,
  output logic [WORD_W-1:0]   wbDataB
);
  logic [ADDR_W-1:0] addrReg;
  logic [IDX_W-1:0]  rtReg, rt2Reg;
  logic              bigReg;
  logic [WORD_W-1:0] loWord, hiWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg       <= '0;
      rtReg         <= '0;
      rt2Reg        <= '0;
      bigReg        <= 1'b0;
      gmonMarkValid <= 1'b0;
      loWord        <= '0;
      hiWord        <= '0;
    end else begin
      gmonMarkValid <= strobe.capture && sharedAttr;
      if (strobe.capture) begin
        addrReg <= baseVal;
        rtReg   <= dec.rt;
        rt2Reg  <= dec.rt2;
        bigReg  <= bigEndian;
      end
      if (strobe.latchRsp) begin
        loWord <= memRspData[WORD_W-1:0];
        hiWord <= memRspData[2*WORD_W-1:WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lmonValid <= 1'b0;
      lmonAddr  <= '0;
    end else if (strobe.capture) begin
      lmonValid <= 1'b1;
      lmonAddr  <= baseVal;
    end else if (lmonClear) begin
      lmonValid <= 1'b0;
    end
  end

  assign memAddr      = addrReg;
  assign gmonMarkAddr = addrReg;
  assign wbIdxA       = rtReg;
  assign wbIdxB       = rt2Reg;
  assign wbDataA      = bigReg ? hiWord : loWord;
  assign wbDataB      = bigReg ? loWord : hiWord;

  p_gmon_tag_r8: assert property (@(posedge clk) disable iff (!rstN)
    gmonMarkValid |-> lmonValid && (lmonAddr == gmonMarkAddr));
  p_mon_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    lmonClear && !strobe.capture |=> !lmonValid);
endmodule

// File: rtl/xld_unit.sv
module xld_unit
  import xld_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [31:0]         instrWord,
  input  logic                halfwordMode,
  input  logic                condPass,
  input  logic                bigEndian,
  input  logic                sharedAttr,
  output logic [IDX_W-1:0]    baseIdx,
  input  logic [ADDR_W-1:0]   baseVal,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [ADDR_W-1:0]   memAddr,
  input  logic                memRspValid,
  input  logic [2*WORD_W-1:0] memRspData,
  output logic                acquireHold,
  output logic                gmonMarkValid,
  output logic [ADDR_W-1:0]   gmonMarkAddr,
  input  logic                lmonClear,
  output logic                lmonValid,
  output logic [ADDR_W-1:0]   lmonAddr,
  output logic                wbEn,
  output logic [IDX_W-1:0]    wbIdxA,
  output logic [WORD_W-1:0]   wbDataA,
  output logic [IDX_W-1:0]    wbIdxB,
  output logic [WORD_W-1:0]   wbDataB,
  output logic                undefInstr,
  output logic                done,
  output logic                busy
);
  xldDecode_t dec;
  ctlStrobe_t strobe;

  assign dec     = decodeWord(instrWord, halfwordMode);
  assign baseIdx = dec.rn;

  xld_control i_ctl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .condPass(condPass),
    .dec(dec), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .strobe(strobe), .memReqValid(memReqValid), .acquireHold(acquireHold),
    .wbEn(wbEn), .done(done), .undefInstr(undefInstr), .busy(busy)
  );

  xld_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dec(dec), .baseVal(baseVal),
    .bigEndian(bigEndian), .sharedAttr(sharedAttr), .memRspData(memRspData),
    .lmonClear(lmonClear), .memAddr(memAddr), .gmonMarkValid(gmonMarkValid),
    .gmonMarkAddr(gmonMarkAddr), .lmonValid(lmonValid), .lmonAddr(lmonAddr),
    .wbIdxA(wbIdxA), .wbDataA(wbDataA), .wbIdxB(wbIdxB), .wbDataB(wbDataB)
  );

  p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memAddr));
  p_undef_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    undefInstr |-> !wbEn && !memReqValid && !gmonMarkValid);
endmodule

// File: tb/test_xld_unit.sv
module test_xld_unit;
  logic        clk = 0;
  logic        rstN = 0;
  logic        issueValid = 0;
  logic [31:0] instrWord = '0;
  logic        halfwordMode = 0, condPass = 1, bigEndian = 0, sharedAttr = 0;
  logic [3:0]  baseIdx;
  logic [31:0] baseVal;
  logic        memReqValid, memReqReady = 0;
  logic [31:0] memAddr;
  logic        memRspValid = 0;
  logic [63:0] memRspData = '0;
  logic        acquireHold, gmonMarkValid, lmonClear = 0, lmonValid;
  logic [31:0] gmonMarkAddr, lmonAddr, wbDataA, wbDataB;
  logic        wbEn, undefInstr, done, busy;
  logic [3:0]  wbIdxA, wbIdxB;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign baseVal = 32'h4000_0008 | (32'(baseIdx) << 12);

  xld_unit i_xld_unit (.*);

  function automatic logic [31:0] addrOf(input logic [3:0] rn);
    return 32'h4000_0008 | (32'(rn) << 12);
  endfunction
  function automatic logic [31:0] wordA1(input logic [3:0] c, rn, rt);
    return {c, 8'h1B, rn, rt, 12'hE9F};
  endfunction
  function automatic logic [31:0] wordT1(input logic [3:0] rn, rt, rt2);
    return {12'hE8D, rn, rt, rt2, 8'hFF};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic hw, input logic cp,
                       input logic be, input logic sh);
    @(negedge clk);
    instrWord = w; halfwordMode = hw; condPass = cp; bigEndian = be; sharedAttr = sh;
    issueValid = 1;
    #1 chk("R12 baseIdx", baseIdx, w[19:16]);
    @(negedge clk);
    issueValid = 0;
  endtask

  task automatic runLoad(input logic [31:0] w, input logic hw, input logic be,
                         input logic sh, input int stall,
                         input logic [3:0] eA, input logic [3:0] eB,
                         input logic [63:0] rsp);
    logic [31:0] ea;
    ea = addrOf(w[19:16]);
    issue(w, hw, 1, be, sh);
    chk("R6 req valid", memReqValid, 1);
    chk("R6 req addr", memAddr, ea);
    chk("R7 lmon valid", lmonValid, 1);
    chk("R7 lmon addr", lmonAddr, ea);
    chk("R8 gmon pulse", gmonMarkValid, sh);
    if (sh) chk("R8 gmon addr", gmonMarkAddr, ea);
    chk("R11 acquire on", acquireHold, 1);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R6 held", memReqValid, 1);
      chk("R6 addr stable", memAddr, ea);
      chk("R8 gmon one cycle", gmonMarkValid, 0);
    end
    memReqReady = 1;
    @(negedge clk);
    memReqReady = 0;
    chk("R6 req drop", memReqValid, 0);
    chk("R11 acquire waiting", acquireHold, 1);
    chk("R10 no early wb", wbEn, 0);
    memRspValid = 1; memRspData = rsp;
    @(negedge clk);
    memRspValid = 0; memRspData = '0;
    chk("R10 wbEn", wbEn, 1);
    chk("R1/R2 wbIdxA", wbIdxA, eA);
    chk("R1/R2 wbIdxB", wbIdxB, eB);
    chk("R9 dataA", wbDataA, be ? rsp[63:32] : rsp[31:0]);
    chk("R9 dataB", wbDataB, be ? rsp[31:0] : rsp[63:32]);
    chk("R11 acquire off", acquireHold, 0);
    chk("R10 done not yet", done, 0);
    @(negedge clk);
    chk("R10 done", done, 1);
    chk("R10 wb once", wbEn, 0);
    chk("R10 no undef", undefInstr, 0);
    @(negedge clk);
    chk("R10 idle", busy, 0);
  endtask

  task automatic runSkip(input string tag, input logic [31:0] w, input logic hw,
                         input logic cp, input logic expUndef);
    logic pv; logic [31:0] pa;
    pv = lmonValid; pa = lmonAddr;
    issue(w, hw, cp, 0, 1);
    chk({tag, " done"}, done, 1);
    chk({tag, " undef"}, undefInstr, expUndef);
    chk({tag, " no req"}, memReqValid, 0);
    chk({tag, " no wb"}, wbEn, 0);
    chk({tag, " no gmon"}, gmonMarkValid, 0);
    chk({tag, " lmon valid kept"}, lmonValid, pv);
    chk({tag, " lmon addr kept"}, lmonAddr, pa);
    @(negedge clk);
    chk({tag, " idle"}, busy, 0);
    chk({tag, " still no wb"}, wbEn, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("reset req", memReqValid, 0);
    chk("reset busy", busy, 0);
    chk("reset lmon", lmonValid, 0);
    chk("reset done", done, 0);
    chk("reset wb", wbEn, 0);
  endtask

  task automatic testClearAndOverwrite();
    runLoad(wordA1(4'h1, 4'd1, 4'd0), 0, 0, 0, 0, 4'd0, 4'd1, 64'h0F0E_0D0C_0B0A_0908);
    runLoad(wordA1(4'h2, 4'd2, 4'd6), 0, 0, 0, 1, 4'd6, 4'd7, 64'h0000_0001_0000_0002);
    chk("R7 overwrite", lmonAddr, addrOf(4'd2));
    @(negedge clk); lmonClear = 1;
    @(negedge clk); lmonClear = 0;
    chk("R7 clear", lmonValid, 0);
    @(negedge clk);
    instrWord = wordT1(4'd5, 4'd3, 4'd8); halfwordMode = 1; condPass = 1;
    sharedAttr = 0; issueValid = 1; lmonClear = 1;
    @(negedge clk);
    issueValid = 0; lmonClear = 0;
    chk("R7 set beats clear", lmonValid, 1);
    chk("R7 set addr", lmonAddr, addrOf(4'd5));
    memReqReady = 1; @(negedge clk); memReqReady = 0;
    memRspValid = 1; @(negedge clk); memRspValid = 0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    runLoad(wordA1(4'hE, 4'd3, 4'd4), 0, 0, 0, 2, 4'd4, 4'd5, 64'h1122_3344_5566_7788);
    runLoad(wordT1(4'd7, 4'd9, 4'd2), 1, 1, 1, 0, 4'd9, 4'd2, 64'hAABB_CCDD_EEFF_0011);
    runLoad(wordT1(4'd0, 4'd11, 4'd10), 1, 0, 1, 3, 4'd11, 4'd10, 64'hDEAD_BEEF_CAFE_F00D);
    runLoad(wordA1(4'h0, 4'd14, 4'd12), 0, 1, 0, 1, 4'd12, 4'd13, 64'h0102_0304_0506_0708);
    runSkip("R3 odd rt", wordA1(4'hE, 4'd3, 4'd5), 0, 1, 1);
    runSkip("R3 rt 14", wordA1(4'hE, 4'd3, 4'd14), 0, 1, 1);
    runSkip("R3 rn 15", wordA1(4'hE, 4'd15, 4'd2), 0, 1, 1);
    runSkip("R3 cond F", wordA1(4'hF, 4'd3, 4'd2), 0, 1, 1);
    runSkip("R3 bad bits", wordA1(4'hE, 4'd3, 4'd2) ^ 32'h0000_0010, 0, 1, 1);
    runSkip("R3 wrong mode", wordA1(4'hE, 4'd3, 4'd2), 1, 1, 1);
    runSkip("R4 rt eq rt2", wordT1(4'd3, 4'd6, 4'd6), 1, 1, 1);
    runSkip("R4 rt2 15", wordT1(4'd3, 4'd6, 4'd15), 1, 1, 1);
    runSkip("R4 rt 15", wordT1(4'd3, 4'd15, 4'd6), 1, 1, 1);
    runSkip("R4 rn 15", wordT1(4'd15, 4'd1, 4'd6), 1, 1, 1);
    runSkip("R5 cond fail", wordA1(4'h1, 4'd8, 4'd2), 0, 0, 0);
    runSkip("R5 cond fail hw", wordT1(4'd8, 4'd1, 4'd2), 1, 0, 0);
    testClearAndOverwrite();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule